// File: doc/BRIEF.md
# Cross-Lane Data Permutation Unit

This block moves 32-bit words between the 64 lanes of a wavefront in a single registered step. The wavefront is split into four rows of 16 lanes, and each row holds four groups of four lanes. A 9-bit control code chooses one of twelve movement patterns. These cover an arbitrary crossbar inside each group of four, shifts and rotates inside a row, one-lane shifts and rotates across the whole wavefront, mirrors of a row or half-row, and two broadcasts from one row into later rows.

Besides the source vector, the block takes an "old" vector. Per lane, a row mask, a bank mask and a bound-control bit decide whether the lane receives the moved word, zero, or its old word. An upstream issue stage presents one operation per cycle with `in_valid`. The merged result appears on the next cycle, marked by `out_valid`. Control codes outside the defined set do not move any data, and they raise a one-cycle `illegal` flag.

Top module: `lane_xbar`

## Requirements
- R1: When ctrl[8] is 0 the code selects the quad crossbar. Lane position q (0–3) inside each group of four takes the word from position ctrl[2q+1:2q] of the same group.
- R2: Code 0x100+n (n = 1..15) is row shift left: a lane at row position p reads position p+n of its row, and no source exists when p+n > 15. Code 0x110+n is row shift right: a lane reads position p−n, and no source exists when p < n.
- R3: Code 0x120+n (n = 1..15) is row rotate right: a lane at row position p reads position (p−n) mod 16 of its row.
- R4: Wave moves by one lane: 0x130 makes lane l read l+1, with no source for lane 63. 0x138 makes lane l read l−1, with no source for lane 0. 0x134 makes lane l read (l+1) mod 64. 0x13C makes lane l read (l−1) mod 64.
- R5: Code 0x140 reverses lane order inside each 16-lane row. Code 0x141 reverses lane order inside each aligned group of 8 lanes.
- R6: Code 0x142 gives every lane of row r ≥ 1 the word of lane 16r−1, and row 0 has no source. Code 0x143 gives every lane of rows 2 and 3 the word of lane 31, and rows 0 and 1 have no source.
- R7: For a defined code, a lane is written only if row_mask[l/16] and bank_mask[l mod 4] are both 1. Every other lane outputs its old word.
- R8: A written lane with no source outputs zero when bound_zero is 1, and its old word when bound_zero is 0.
- R9: Any other code, including the shift and rotate codes with n = 0, outputs the source vector unchanged whatever the masks are. It also raises `illegal` together with `out_valid` for that one cycle only.
- R10: `out_vec` and `out_valid` change one clock edge after an accepted input, and `out_valid` is low in every cycle that follows no input. A synchronous active-high reset clears `out_valid` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| src_vec | input | 2048 | Source words, lane l at bits [32l+31:32l] |
| old_vec | input | 2048 | Old words, same lane layout |
| ctrl | input | 9 | Movement control code |
| row_mask | input | 4 | Per-row write enable |
| bank_mask | input | 4 | Per-bank (lane mod 4) write enable |
| bound_zero | input | 1 | Missing source gives zero (1) or old word (0) |
| out_valid | output | 1 | Result valid |
| out_vec | output | 2048 | Merged result |
| illegal | output | 1 | Undefined control code seen |

## Verification
The embedded assertions are checked on every cycle. They cover the one-cycle valid timing, the rule that `illegal` appears only together with `out_valid`, pass-through of the source on undefined codes, the all-old result when the row mask is zero, and the identity quad pattern. Which lane feeds which lane for each movement family is shown only by the bench's scenarios. So are the missing-source edges at row and wavefront ends, the broadcast row coverage and the interaction of the bank mask with bound control. The bench compares these against a lane model written from the requirements.

// File: rtl/lane_xbar.sv
module lane_xbar #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  parameter int ROW   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] src_vec,
  input  logic [LANES*DW-1:0] old_vec,
  input  logic [8:0]          ctrl,
  input  logic [3:0]          row_mask,
  input  logic [3:0]          bank_mask,
  input  logic                bound_zero,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_vec,
  output logic                illegal
);
  localparam int LW = $clog2(LANES);

  typedef enum logic [3:0] {
    OP_QUAD, OP_SHL, OP_SHR, OP_ROR, OP_WSHL, OP_WROL, OP_WSHR, OP_WROR,
    OP_MIR, OP_HMIR, OP_B15, OP_B31, OP_PASS
  } op_t;

  op_t        op;
  logic [3:0] amt;
  logic [LANES*DW-1:0] nxt_vec;

  assign amt = ctrl[3:0];

  always_comb begin
    op = OP_PASS;
    if (!ctrl[8]) op = OP_QUAD;
    else begin
      case (ctrl[7:4])
        4'h0: if (amt != 4'd0) op = OP_SHL;
        4'h1: if (amt != 4'd0) op = OP_SHR;
        4'h2: if (amt != 4'd0) op = OP_ROR;
        4'h3: case (amt)
                4'd0:  op = OP_WSHL;
                4'd4:  op = OP_WROL;
                4'd8:  op = OP_WSHR;
                4'd12: op = OP_WROR;
                default: op = OP_PASS;
              endcase
        4'h4: case (amt)
                4'd0: op = OP_MIR;
                4'd1: op = OP_HMIR;
                4'd2: op = OP_B15;
                4'd3: op = OP_B31;
                default: op = OP_PASS;
              endcase
        default: op = OP_PASS;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int P  = g % ROW;
    localparam int RB = g - P;
    localparam int Q  = g % 4;
    localparam int H  = g % 8;
    int         s;
    logic       oob;
    logic       wr;
    logic [LW-1:0] sidx;
    logic [DW-1:0] moved, oldw;

    always_comb begin
      s   = g;
      oob = 1'b0;
      case (op)
        OP_QUAD: s = (g - Q) + int'(ctrl[2*Q +: 2]);
        OP_SHL:  begin s = g + int'(amt); oob = (P + int'(amt)) > (ROW - 1); end
        OP_SHR:  begin s = g - int'(amt); oob = P < int'(amt); end
        OP_ROR:  s = RB + ((P - int'(amt) + ROW) % ROW);
        OP_WSHL: begin s = g + 1; oob = (g == LANES - 1); end
        OP_WROL: s = (g + 1) % LANES;
        OP_WSHR: begin s = g - 1; oob = (g == 0); end
        OP_WROR: s = (g + LANES - 1) % LANES;
        OP_MIR:  s = RB + ROW - 1 - P;
        OP_HMIR: s = (g - H) + 7 - H;
        OP_B15:  begin s = RB - 1; oob = (RB == 0); end
        OP_B31:  begin s = 2*ROW - 1; oob = (RB < 2*ROW); end
        default: s = g;
      endcase
      if (oob) s = g;
      sidx = s[LW-1:0];
    end

    assign moved = src_vec[sidx*DW +: DW];
    assign oldw  = old_vec[g*DW +: DW];
    assign wr    = row_mask[g/ROW] & bank_mask[Q];
    assign nxt_vec[g*DW +: DW] = (op == OP_PASS) ? src_vec[g*DW +: DW] :
                                 !wr             ? oldw :
                                 oob             ? (bound_zero ? '0 : oldw) :
                                                   moved;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      illegal   <= in_valid && (op == OP_PASS);
    end
    if (in_valid) out_vec <= nxt_vec;
  end

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r9_flag_with_valid: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);
  a_r9_pass_source: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_PASS) |=> (illegal && out_vec == $past(src_vec)));
  a_r7_rows_closed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != OP_PASS && row_mask == 4'h0) |=> out_vec == $past(old_vec));
  a_r1_quad_identity: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl == 9'h0E4 && row_mask == 4'hF && bank_mask == 4'hF)
      |=> out_vec == $past(src_vec));
endmodule

// File: tb/sim_lane_xbar.sv
`timescale 1ns/1ps
module sim_lane_xbar;
  localparam int LANES = 64;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [LANES*DW-1:0] src_vec = '0, old_vec = '0;
  logic [8:0] ctrl = '0;
  logic [3:0] row_mask = 4'hF, bank_mask = 4'hF;
  logic bound_zero = 1'b0;
  logic out_valid, illegal;
  logic [LANES*DW-1:0] out_vec;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_xbar u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .old_vec(old_vec), .ctrl(ctrl), .row_mask(row_mask), .bank_mask(bank_mask),
    .bound_zero(bound_zero), .out_valid(out_valid), .out_vec(out_vec), .illegal(illegal));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit code_ok(input logic [8:0] c);
    int v = int'(c);
    if (v < 256) return 1;
    if ((v > 'h100 && v <= 'h10F) || (v > 'h110 && v <= 'h11F) || (v > 'h120 && v <= 'h12F)) return 1;
    if (v == 'h130 || v == 'h134 || v == 'h138 || v == 'h13C) return 1;
    if (v >= 'h140 && v <= 'h143) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_lane(input int l, input logic [8:0] c,
      input logic [3:0] rm, input logic [3:0] bm, input bit bc);
    int v = int'(c);
    int row = l / 16, pos = l % 16, n = v % 16, s = l;
    bit have = 1;
    logic [31:0] o = old_vec[l*DW +: DW];
    if (!code_ok(c)) return src_vec[l*DW +: DW];
    if (v < 256) s = 4*(l/4) + ((v >> (2*(l%4))) & 3);
    else if (v < 'h110) begin have = (pos + n) < 16; s = l + n; end
    else if (v < 'h120) begin have = pos >= n; s = l - n; end
    else if (v < 'h130) s = row*16 + (pos + 16 - n) % 16;
    else if (v == 'h130) begin have = l < 63; s = l + 1; end
    else if (v == 'h134) s = (l + 1) % 64;
    else if (v == 'h138) begin have = l > 0; s = l - 1; end
    else if (v == 'h13C) s = (l + 63) % 64;
    else if (v == 'h140) s = row*16 + 15 - pos;
    else if (v == 'h141) s = 8*(l/8) + 7 - l%8;
    else if (v == 'h142) begin have = row > 0; s = row*16 - 1; end
    else begin have = row >= 2; s = 31; end
    if (!(rm[row] && bm[l%4])) return o;
    if (!have) return bc ? 32'h0 : o;
    return src_vec[s*DW +: DW];
  endfunction

  task automatic apply(input logic [8:0] c, input logic [3:0] rm, input logic [3:0] bm,
      input bit bc, input string req);
    int bad = -1;
    logic [31:0] e;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      src_vec[l*DW +: DW] = $urandom;
      old_vec[l*DW +: DW] = $urandom;
    end
    ctrl = c; row_mask = rm; bank_mask = bm; bound_zero = bc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " R10 valid"}, 64'(out_valid), 64'd1);
    chk(illegal === !code_ok(c), {req, " R9 flag"}, 64'(illegal), 64'(!code_ok(c)));
    for (int l = 0; l < LANES; l++) begin
      e = ref_lane(l, c, rm, bm, bc);
      if (bad < 0 && out_vec[l*DW +: DW] !== e) begin
        bad = l;
        chk(0, $sformatf("%s data lane %0d", req, l), 64'(out_vec[l*DW +: DW]), 64'(e));
      end
    end
    if (bad < 0) chk(1, req, 0, 0);
    @(negedge clk);
    chk(out_valid === 1'b0 && illegal === 1'b0, {req, " R10 idle"},
        64'({out_valid, illegal}), 64'd0);
  endtask

  task automatic t_reset;
    chk(out_valid === 1'b0 && illegal === 1'b0, "R10 reset", 64'({out_valid, illegal}), 64'd0);
  endtask
  task automatic t_quad;
    apply(9'h0E4, 4'hF, 4'hF, 0, "R1 identity");
    apply(9'h01B, 4'hF, 4'hF, 0, "R1 reverse");
    apply(9'h000, 4'hF, 4'hF, 0, "R1 splat");
    apply(9'h0B1, 4'hF, 4'hF, 1, "R1 swap");
  endtask
  task automatic t_row_shift;
    apply(9'h101, 4'hF, 4'hF, 1, "R2 shl1 zero");
    apply(9'h10F, 4'hF, 4'hF, 0, "R2 shl15 old");
    apply(9'h113, 4'hF, 4'hF, 1, "R2 shr3 zero");
    apply(9'h113, 4'hF, 4'hF, 0, "R2 shr3 old");
  endtask
  task automatic t_row_ror;
    apply(9'h121, 4'hF, 4'hF, 0, "R3 ror1");
    apply(9'h12F, 4'hF, 4'hF, 1, "R3 ror15");
    apply(9'h127, 4'hF, 4'hF, 0, "R3 ror7");
  endtask
  task automatic t_wave;
    apply(9'h130, 4'hF, 4'hF, 1, "R4 wshl");
    apply(9'h134, 4'hF, 4'hF, 1, "R4 wrol");
    apply(9'h138, 4'hF, 4'hF, 0, "R4 wshr");
    apply(9'h13C, 4'hF, 4'hF, 0, "R4 wror");
  endtask
  task automatic t_mirror;
    apply(9'h140, 4'hF, 4'hF, 0, "R5 mirror");
    apply(9'h141, 4'hF, 4'hF, 0, "R5 half mirror");
  endtask
  task automatic t_bcast;
    apply(9'h142, 4'hF, 4'hF, 1, "R6 bcast15 zero");
    apply(9'h142, 4'hA, 4'hF, 0, "R6 bcast15 masked");
    apply(9'h143, 4'hF, 4'hF, 1, "R6 bcast31 zero");
    apply(9'h143, 4'hF, 4'hF, 0, "R6 bcast31 old");
  endtask
  task automatic t_masks;
    apply(9'h101, 4'h5, 4'h3, 1, "R7 R8 partial masks");
    apply(9'h140, 4'h0, 4'hF, 0, "R7 rows closed");
    apply(9'h134, 4'hF, 4'h0, 0, "R7 banks closed");
    apply(9'h138, 4'h1, 4'h1, 1, "R8 lane0 edge");
  endtask
  task automatic t_illegal;
    apply(9'h100, 4'h0, 4'h0, 1, "R9 shl0");
    apply(9'h120, 4'hF, 4'hF, 1, "R9 ror0");
    apply(9'h135, 4'hF, 4'h3, 0, "R9 wave gap");
    apply(9'h1FF, 4'h0, 4'hF, 1, "R9 top code");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_quad();
    t_row_shift();
    t_row_ror();
    t_wave();
    t_mirror();
    t_bcast();
    t_masks();
    t_illegal();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule